// File: doc/BRIEF.md
# Control Register Access Executor

This block executes the instructions that read and modify a processor's control and status registers. Each cycle it can accept one 32-bit instruction word, the current privilege level, and the two general-register operands that the register file has already read. It recognises one major opcode. Inside that opcode the rj field chooses one of three forms: a plain read, a plain write, or a masked exchange. The block then drives an address, write data and write enable into a separate register bank, which returns read data combinationally. The block also returns the value that the destination register should receive.

The bank address and the write enable come straight from the incoming instruction in the same cycle, so the bank commits a write at the clock edge that accepts the instruction. The writeback, the two exception pulses and the pipeline-resync request are registered and appear one cycle later. Three properties of each register address come from parameters: whether a register exists there, whether it is read-only, and whether writing it changes the machine mode so that later instructions have to be refetched. Register side effects belong to the bank.

Top module: `csr_exec_unit`

## Requirements
- R1: Only an instruction whose bits [31:24] equal 8'h04 is acted on. The address is bits [23:10], rj is bits [9:5] and rd is bits [4:0]. Any other top byte gives no bank write, no writeback and no exception.
- R2: With rj = 0 (read), and when no exception applies, wb_data carries the bank contents at the address and bank_we stays low.
- R3: With rj = 1 (write), bank_we is asserted with bank_wdata = rd_val, and wb_data returns the value the register held before the write.
- R4: With rj >= 2 (exchange), rj_val is the mask. The bank receives (rd_val & mask) | (old & ~mask), and wb_data returns the old value.
- R5: At user privilege (priv_lvl = 3) every form raises exc_priv and produces no bank write and no writeback.
- R6: An address at or above DEF_COUNT (default 48) holds no register. The access returns zero through the writeback, and a write or exchange to it does not reach the bank.
- R7: A write or exchange to an address in RO_LO..RO_HI (default 8..11) raises exc_illegal, with no bank write and no writeback. A read of such an address succeeds.
- R8: An accepted write or exchange to an address in MODE_LO..MODE_HI (default 0..2) raises resync. Reads and other addresses do not.
- R9: When the rd field is 0, wb_valid stays low. A bank write caused by the same instruction still takes place.
- R10: wb_valid, wb_idx, wb_data, exc_priv, exc_illegal and resync are registered. Each is a one-cycle pulse that follows a cycle in which insn_valid was high, and all of them are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| priv_lvl | input | 2 | Current privilege level, 3 is user |
| rj_val | input | XLEN | Value of general register rj (exchange mask) |
| rd_val | input | XLEN | Value of general register rd (source data) |
| bank_addr | output | 14 | Register bank address |
| bank_rdata | input | XLEN | Register bank read data, combinational |
| bank_wdata | output | XLEN | Register bank write data |
| bank_we | output | 1 | Register bank write enable |
| wb_valid | output | 1 | Destination writeback valid |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | XLEN | Destination writeback value |
| exc_priv | output | 1 | Privilege-instruction exception pulse |
| exc_illegal | output | 1 | Illegal-instruction exception pulse |
| resync | output | 1 | Refetch-from-next-PC request pulse |

## Verification
The bank-side results (bank_we and bank_wdata) are combinational in the cycle the instruction is presented. The bench drives inputs on the falling edge and samples these outputs shortly afterwards, before the rising edge. The writeback, exception and resync outputs are due one register later, so they are sampled at the falling edge that follows the accepting rising edge, and the bank model's contents are compared at that same point. A separate idle cycle with insn_valid low confirms that every registered pulse has returned to zero after exactly one cycle.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

    localparam int CSR_ADDR_W = 14;
    localparam int GPR_IDX_W  = 5;

    localparam logic [7:0] CSR_MAJOR_OP = 8'h04;
    localparam logic [1:0] PRIV_USER    = 2'd3;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_XCHG  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [CSR_ADDR_W-1:0] addr;
        logic [GPR_IDX_W-1:0]  rd;
        acc_kind_e             kind;
    } csr_fields_t;

    typedef struct packed {
        logic present;
        logic read_only;
        logic mode_aff;
    } csr_attr_t;

endpackage

// File: rtl/csr_insn_decode.sv
module csr_insn_decode
    import csr_exec_pkg::*;
(
    input  logic [31:0] insn,
    output csr_fields_t fields
);

    logic                  op_hit;
    logic [GPR_IDX_W-1:0]  rj_fld;

    always_comb begin
        op_hit         = (insn[31:24] == CSR_MAJOR_OP);
        rj_fld         = insn[9:5];
        fields.addr    = insn[23:10];
        fields.rd      = insn[4:0];
        if (!op_hit) begin
            fields.kind = ACC_NONE;
        end else if (rj_fld == 5'd0) begin
            fields.kind = ACC_READ;
        end else if (rj_fld == 5'd1) begin
            fields.kind = ACC_WRITE;
        end else begin
            fields.kind = ACC_XCHG;
        end
    end

endmodule

// File: rtl/csr_attr_map.sv
module csr_attr_map
    import csr_exec_pkg::*;
#(
    parameter int DEF_COUNT = 48,
    parameter int RO_LO     = 8,
    parameter int RO_HI     = 11,
    parameter int MODE_LO   = 0,
    parameter int MODE_HI   = 2
) (
    input  logic [CSR_ADDR_W-1:0] addr,
    output csr_attr_t             attr
);

    localparam int SPACE = 1 << CSR_ADDR_W;

    logic present_w;
    logic ro_range;
    logic mode_range;

    generate
        if (DEF_COUNT >= SPACE) begin : g_full_space
            assign present_w = 1'b1;
        end else begin : g_partial_space
            assign present_w = (addr < CSR_ADDR_W'(DEF_COUNT));
        end
    endgenerate

    assign ro_range   = (addr >= CSR_ADDR_W'(RO_LO))   && (addr <= CSR_ADDR_W'(RO_HI));
    assign mode_range = (addr >= CSR_ADDR_W'(MODE_LO)) && (addr <= CSR_ADDR_W'(MODE_HI));

    always_comb begin
        attr.present   = present_w;
        attr.read_only = present_w && ro_range;
        attr.mode_aff  = present_w && mode_range;
    end

endmodule

// File: rtl/csr_merge_unit.sv
module csr_merge_unit #(
    parameter int XLEN = 64
) (
    input  logic            is_xchg,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] mask_val,
    output logic [XLEN-1:0] new_val
);

    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        assign new_val[b] = (is_xchg && !mask_val[b]) ? old_val[b] : src_val[b];
    end

endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int DEF_COUNT = 48,
    parameter int RO_LO     = 8,
    parameter int RO_HI     = 11,
    parameter int MODE_LO   = 0,
    parameter int MODE_HI   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  insn_valid,
    input  logic [31:0]           insn,
    input  logic [1:0]            priv_lvl,
    input  logic [XLEN-1:0]       rj_val,
    input  logic [XLEN-1:0]       rd_val,
    output logic [CSR_ADDR_W-1:0] bank_addr,
    input  logic [XLEN-1:0]       bank_rdata,
    output logic [XLEN-1:0]       bank_wdata,
    output logic                  bank_we,
    output logic                  wb_valid,
    output logic [GPR_IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]       wb_data,
    output logic                  exc_priv,
    output logic                  exc_illegal,
    output logic                  resync
);

    typedef struct packed {
        logic                 wb_valid;
        logic [GPR_IDX_W-1:0] wb_idx;
        logic [XLEN-1:0]      wb_data;
        logic                 exc_priv;
        logic                 exc_ill;
        logic                 resync;
    } res_t;

    localparam res_t RES_IDLE = '0;

    csr_fields_t      fields;
    csr_attr_t        attr;
    logic [XLEN-1:0]  merged;
    logic             is_xchg;
    logic             is_write;
    logic             access;
    logic             is_user;
    logic             blocked_ro;
    logic             commit_we;
    res_t             res_d;
    res_t             res_q;

    csr_insn_decode u_decode (
        .insn   (insn),
        .fields (fields)
    );

    csr_attr_map #(
        .DEF_COUNT (DEF_COUNT),
        .RO_LO     (RO_LO),
        .RO_HI     (RO_HI),
        .MODE_LO   (MODE_LO),
        .MODE_HI   (MODE_HI)
    ) u_attr (
        .addr (fields.addr),
        .attr (attr)
    );

    csr_merge_unit #(
        .XLEN (XLEN)
    ) u_merge (
        .is_xchg  (is_xchg),
        .old_val  (bank_rdata),
        .src_val  (rd_val),
        .mask_val (rj_val),
        .new_val  (merged)
    );

    always_comb begin
        is_xchg    = (fields.kind == ACC_XCHG);
        is_write   = (fields.kind == ACC_WRITE) || is_xchg;
        access     = insn_valid && (fields.kind != ACC_NONE);
        is_user    = (priv_lvl == PRIV_USER);
        blocked_ro = is_write && attr.read_only;
        commit_we  = access && !is_user && attr.present && is_write && !blocked_ro;

        res_d = RES_IDLE;
        if (access) begin
            if (is_user) begin
                res_d.exc_priv = 1'b1;
            end else if (!attr.present) begin
                res_d.wb_valid = (fields.rd != '0);
                res_d.wb_data  = '0;
            end else if (blocked_ro) begin
                res_d.exc_ill = 1'b1;
            end else begin
                res_d.wb_valid = (fields.rd != '0);
                res_d.wb_data  = bank_rdata;
                res_d.resync   = is_write && attr.mode_aff;
            end
        end
        if (!res_d.wb_valid) begin
            res_d.wb_data = '0;
        end
        res_d.wb_idx = res_d.wb_valid ? fields.rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_IDLE;
        end else begin
            res_q <= res_d;
        end
    end

    assign bank_addr   = fields.addr;
    assign bank_wdata  = merged;
    assign bank_we     = commit_we;
    assign wb_valid    = res_q.wb_valid;
    assign wb_idx      = res_q.wb_idx;
    assign wb_data     = res_q.wb_data;
    assign exc_priv    = res_q.exc_priv;
    assign exc_illegal = res_q.exc_ill;
    assign resync      = res_q.resync;

endmodule

// File: rtl/csr_exec_chk.sv
module csr_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       insn_valid,
    input logic [7:0] insn_op,
    input logic [1:0] priv_lvl,
    input logic       bank_we,
    input logic       wb_valid,
    input logic [4:0] wb_idx,
    input logic       exc_priv,
    input logic       exc_illegal,
    input logic       resync
);

    // R1
    op_mismatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_op != 8'h04) |-> !bank_we);

    // R5
    user_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && priv_lvl == 2'd3) |-> !bank_we);

    // R5
    priv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_priv |-> (!wb_valid && !exc_illegal && !resync));

    // R7
    ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_illegal |-> (!wb_valid && !resync));

    // R8
    resync_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(bank_we));

    // R9
    no_r0_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx != 5'd0));

    // R10
    result_from_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid || exc_priv || exc_illegal || resync) |-> $past(insn_valid));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !(wb_valid || exc_priv || exc_illegal || resync));

endmodule

bind csr_exec_unit csr_exec_chk i_csr_exec_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_valid  (insn_valid),
    .insn_op     (insn[31:24]),
    .priv_lvl    (priv_lvl),
    .bank_we     (bank_we),
    .wb_valid    (wb_valid),
    .wb_idx      (wb_idx),
    .exc_priv    (exc_priv),
    .exc_illegal (exc_illegal),
    .resync      (resync)
);

// File: tb/test_csr_exec_unit.sv
module test_csr_exec_unit;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 64;
    localparam int NDEF       = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            insn_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [1:0]      priv_lvl = '0;
    logic [XLEN-1:0] rj_val = '0;
    logic [XLEN-1:0] rd_val = '0;
    logic [13:0]     bank_addr;
    logic [XLEN-1:0] bank_rdata;
    logic [XLEN-1:0] bank_wdata;
    logic            bank_we;
    logic            wb_valid;
    logic [4:0]      wb_idx;
    logic [XLEN-1:0] wb_data;
    logic            exc_priv;
    logic            exc_illegal;
    logic            resync;

    logic [XLEN-1:0] mem     [NDEF];
    logic [XLEN-1:0] exp_mem [NDEF];

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_exec_unit i_csr_exec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_valid  (insn_valid),
        .insn        (insn),
        .priv_lvl    (priv_lvl),
        .rj_val      (rj_val),
        .rd_val      (rd_val),
        .bank_addr   (bank_addr),
        .bank_rdata  (bank_rdata),
        .bank_wdata  (bank_wdata),
        .bank_we     (bank_we),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .wb_data     (wb_data),
        .exc_priv    (exc_priv),
        .exc_illegal (exc_illegal),
        .resync      (resync)
    );

    // Bank model: garbage outside the defined range so a zero result is meaningful.
    assign bank_rdata = (bank_addr < 14'(NDEF)) ? mem[bank_addr[5:0]] : 64'hBAD0_BAD0_BAD0_BAD0;

    always @(posedge clk) begin
        if (bank_we && bank_addr < 14'(NDEF)) begin
            mem[bank_addr[5:0]] <= bank_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_quiet(input string tag);
        chk(wb_valid == 1'b0,    tag, 64'(wb_valid), 64'd0);
        chk(wb_data == '0,       tag, wb_data, 64'd0);
        chk(exc_priv == 1'b0,    tag, 64'(exc_priv), 64'd0);
        chk(exc_illegal == 1'b0, tag, 64'(exc_illegal), 64'd0);
        chk(resync == 1'b0,      tag, 64'(resync), 64'd0);
    endtask

    // Called at a falling edge; returns at the falling edge after the accepting edge.
    task automatic run_op(input int addr, input int form, input int p, input int rdi,
                          input logic [63:0] rdv, input logic [63:0] mask);
        logic [4:0]  rjf;
        bit          user, present, ro, mode, is_wr, okacc, exp_we, exp_wbv;
        logic [63:0] old, newv, exp_data;
        string       tag;
        rjf     = (form == 0) ? 5'd0 : (form == 1) ? 5'd1 : 5'(2 + (addr % 30));
        user    = (p == 3);
        present = (addr < NDEF);
        ro      = present && addr >= 8 && addr <= 11;
        mode    = present && addr <= 2;
        is_wr   = (form != 0);
        old     = present ? exp_mem[addr] : 64'd0;
        newv    = (form == 1) ? rdv : ((rdv & mask) | (old & ~mask));
        okacc   = !user && !(is_wr && ro);
        exp_we  = !user && present && is_wr && !ro;
        exp_wbv = okacc && (rdi != 0);
        exp_data = exp_wbv ? old : 64'd0;
        if (user) tag = "R5";
        else if (!present) tag = "R6";
        else if (is_wr && ro) tag = "R7";
        else if (rdi == 0) tag = "R9";
        else if (form == 0) tag = "R2";
        else if (form == 1) tag = "R3";
        else tag = "R4";

        insn_valid = 1'b1;
        insn       = {8'h04, 14'(addr), rjf, 5'(rdi)};
        priv_lvl   = 2'(p);
        rd_val     = rdv;
        rj_val     = mask;
        #1;
        chk(bank_we == exp_we, tag, 64'(bank_we), 64'(exp_we));
        if (exp_we) chk(bank_wdata == newv, tag, bank_wdata, newv);
        @(posedge clk);
        @(negedge clk);
        insn_valid = 1'b0;
        if (exp_we) exp_mem[addr] = newv;
        chk(wb_valid == exp_wbv, tag, 64'(wb_valid), 64'(exp_wbv));
        chk(wb_data == exp_data, tag, wb_data, exp_data);
        if (exp_wbv) chk(wb_idx == 5'(rdi), tag, 64'(wb_idx), 64'(rdi));
        chk(exc_priv == user, "R5", 64'(exc_priv), 64'(user));
        chk(exc_illegal == (!user && is_wr && ro), "R7", 64'(exc_illegal), 64'(!user && is_wr && ro));
        chk(resync == (exp_we && mode), "R8", 64'(resync), 64'(exp_we && mode));
        if (present) chk(mem[addr] == exp_mem[addr], tag, mem[addr], exp_mem[addr]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NDEF; i++) begin
            mem[i]     = {32'h5A00_0000 | 32'(i), 32'hC0DE_0000 ^ 32'(i * 17)};
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check_quiet("R10");
        chk(bank_we == 1'b0, "R10", 64'(bank_we), 64'd0);

        // Near-exhaustive sweep: addresses, forms, privilege levels
        for (int a = 0; a < 64; a++) begin
            for (int f = 0; f < 3; f++) begin
                for (int p = 0; p < 4; p++) begin
                    run_op(a, f, p, (a * 3 + f + p) % 32,
                           {16'(a * 7 + f), 16'(p * 11 + 3), 16'hC3A5 ^ 16'(a), 16'(a * 13)},
                           {32'hFF00_FF00 ^ 32'(a * 5), 32'h0F0F_3C3C ^ 32'(f * 9 + p)});
                end
            end
        end

        // R6 far undefined address, exchange and write
        run_op(16383, 2, 0, 7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_FFFF_0000);
        run_op(9000, 1, 1, 9, 64'h1234_5678_9ABC_DEF0, 64'd0);

        // R4 exchange with all-zero and all-one masks
        run_op(20, 2, 0, 5, 64'h0123_4567_89AB_CDEF, 64'd0);
        run_op(21, 2, 0, 6, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);

        // R1 wrong major opcode: no access, no results
        for (int op = 0; op < 256; op++) begin
            if (op != 8'h04) begin
                insn_valid = 1'b1;
                insn       = {8'(op), 14'(op % 40), 5'(op % 3), 5'd3};
                priv_lvl   = 2'(op % 4);
                rd_val     = 64'hDEAD_BEEF_0000_0000 | 64'(op);
                rj_val     = 64'hFFFF;
                #1;
                chk(bank_we == 1'b0, "R1", 64'(bank_we), 64'd0);
                @(posedge clk);
                @(negedge clk);
                insn_valid = 1'b0;
                check_quiet("R1");
            end
        end
        for (int i = 0; i < NDEF; i++) begin
            chk(mem[i] == exp_mem[i], "R1", mem[i], exp_mem[i]);
        end

        // R10 insn_valid low with a matching write: nothing happens
        insn_valid = 1'b0;
        insn       = {8'h04, 14'd1, 5'd1, 5'd4};
        priv_lvl   = 2'd0;
        rd_val     = 64'h7777_7777_7777_7777;
        #1;
        chk(bank_we == 1'b0, "R10", 64'(bank_we), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check_quiet("R10");
        chk(mem[1] == exp_mem[1], "R10", mem[1], exp_mem[1]);

        // R10 pulse: a resync-producing write then one idle cycle
        run_op(0, 1, 0, 12, 64'hAAAA_5555_AAAA_5555, 64'd0);
        @(posedge clk);
        @(negedge clk);
        check_quiet("R10");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule